// File: doc/BRIEF.md
# Dual-Mode Video Output Timing Generator

This block turns a stream of 4:2:2 pixels into a timed digital video output running on a 27 MHz clock. It counts clocks along each line and lines down each frame. From those counts it derives a horizontal active flag (`hrefOut`), a vertical blanking flag (`vsyncOut`) and an active-low composite sync (`csyncOut`), for either a 625-line/50 Hz or a 525-line/60 Hz raster. Pixels arrive one per beat over a ready/valid interface. Each beat carries one luma sample and one chroma sample; the chroma is Cb on even pixels and Cr on odd pixels.

The output format can be changed at run time. In the wide format, luma leaves on `lumaOut` and the alternating Cb/Cr samples leave on `chromaOut`, each held for two clocks. A 13.5 MHz qualifier (`qualOut`) marks the first clock of every sample. In the narrow format, `lumaOut` carries a Cb, Y, Cr, Y byte multiplex at the full clock rate, with four-byte timing codes around the active window, and `chromaOut` is parked at its blanking value. The format and line standard inputs are sampled only at frame boundaries, so the output never changes format part-way through a frame.

Top module: `vid_out_timing`

## Requirements
- R1: A line lasts LINE_625 clocks (default 1728) when the latched standard is 625, and LINE_525 clocks (default 1716) when it is 525. A frame lasts LINES_625 or LINES_525 lines.
- R2: `hrefOut` is high for exactly 2*ACT_PIX clocks per line, which is 720 pixels by default. It starts START_625 (264) or START_525 (244) clocks after the line start, where `csyncOut` falls. It is low on vertical blanking lines.
- R3: Lines 0..FIELD0-1 form field 0 and the remaining lines form field 1. `vsyncOut` is high on the first VBLANK_625/VBLANK_525 lines of each field and low elsewhere.
- R4: On ordinary lines, `csyncOut` is low for the first HSYNC_W clocks. On the first VSYNC_LINES lines of each field, it is low from the line start until HSYNC_W clocks before the line end.
- R5: In the wide format (`wideMode`=1), each active pixel holds its Y on `lumaOut` and its chroma on `chromaOut` for two clocks. Pixel 0 carries Cb and pixel 1 carries Cr. `qualOut` is high on the first of the two clocks and low on the second, all along the line.
- R6: In the narrow format (`wideMode`=0), `lumaOut` carries Cb0, Y0, Cr1, Y1, and so on, with one byte per clock. `chromaOut` stays at 0x80 and `qualOut` stays low.
- R7: In the narrow format, the four clocks before the active window carry FF 00 00 XY, and so do the four clocks after it. XY = {1, F, V, H, V^H, F^H, F^V, F^V^H} from bit 7 down to bit 0. F is the field, V is the vertical blanking flag, and H is 0 before the window and 1 after it.
- R8: Outside the active picture, the wide format drives luma 0x10 and chroma 0x80. The narrow format drives 0x80 on even clock offsets from the window start and 0x10 on odd offsets.
- R9: `pixReady` is high exactly on the first clock of each active pixel, and only on non-blanking lines. If `pixValid` is low at that clock, the pixel is sent as luma 0x10 and chroma 0x80.
- R10: `wideMode` and `std625` are sampled only on the last clock of a frame. A change in the middle of a frame has no effect on that frame.
- R11: During reset, the outputs are luma 0x10, chroma 0x80, `hrefOut`/`vsyncOut`/`qualOut` low, `csyncOut` high and `pixReady` low. Line 0, clock 0 appears on the outputs after the second clock edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wideMode | input | 1 | 1 = wide luma/chroma format, 0 = narrow multiplex |
| std625 | input | 1 | 1 = 625-line standard, 0 = 525-line |
| pixValid | input | 1 | Upstream pixel beat valid |
| pixY | input | 8 | Luma of the beat |
| pixC | input | 8 | Chroma of the beat (Cb even pixel, Cr odd) |
| pixReady | output | 1 | Beat accepted on this clock edge |
| lumaOut | output | 8 | Luma bus or narrow multiplex |
| chromaOut | output | 8 | Chroma bus (wide format) |
| qualOut | output | 1 | 13.5 MHz sample qualifier |
| hrefOut | output | 1 | Active part of the line |
| vsyncOut | output | 1 | Vertical blanking of the field |
| csyncOut | output | 1 | Composite sync, active low |

## Verification
The bench shrinks the raster to 8 pixels per line. Lines are 40 clocks (625) or 36 clocks (525), and frames are 11 or 9 lines with two blanking lines per field. At that size one run crosses every field boundary, sync line and code slot many times. It covers all four format/standard combinations over five frames. The inputs for each next frame are changed in the middle of the running frame, and an irregular valid pattern forces underruns.

// File: rtl/vot_pkg.sv
package vot_pkg;

  localparam logic [7:0] LUMA_BLANK   = 8'h10;
  localparam logic [7:0] CHROMA_BLANK = 8'h80;

  typedef struct packed {
    logic       live;      // counters running with a loaded configuration
    logic       wide;      // wide luma/chroma format for this frame
    logic       active;    // column inside the active window
    logic       even;      // even clock offset from window start
    logic       vblank;    // line inside vertical blanking
    logic       fieldId;   // second field
    logic       savSlot;   // code slot ahead of the window
    logic       eavSlot;   // code slot after the window
    logic [1:0] codeIdx;   // byte index inside the code slot
    logic       csyncLow;  // composite sync asserted
  } vot_strobe_t;

  function automatic logic [7:0] codeWord(logic f, logic v, logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/vot_ctrl.sv
module vot_ctrl
  import vot_pkg::*;
#(
  parameter int ACT_PIX     = 720,
  parameter int LINE_625    = 1728,
  parameter int LINE_525    = 1716,
  parameter int START_625   = 264,
  parameter int START_525   = 244,
  parameter int LINES_625   = 625,
  parameter int LINES_525   = 525,
  parameter int FIELD0_625  = 312,
  parameter int FIELD0_525  = 262,
  parameter int VBLANK_625  = 24,
  parameter int VBLANK_525  = 21,
  parameter int HSYNC_W     = 128,
  parameter int VSYNC_LINES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wideMode,
  input  logic        std625,
  output vot_strobe_t strb
);
  localparam int MAXL     = (LINE_625 > LINE_525) ? LINE_625 : LINE_525;
  localparam int MAXV     = (LINES_625 > LINES_525) ? LINES_625 : LINES_525;
  localparam int HW       = $clog2(MAXL);
  localparam int VW       = $clog2(MAXV);
  localparam int ACT_SPAN = 2 * ACT_PIX;

  logic [HW-1:0] hCnt, lineLast, actStart;
  logic [VW-1:0] vCnt, frameLast, field0, vblLines, lineInField;
  logic [HW:0]   colRel, eavOff, syncEnd;
  logic          cfgWide, cfgStd, primed, inF2, afterStart, syncLine;

  always_comb begin
    lineLast  = cfgStd ? HW'(LINE_625 - 1)  : HW'(LINE_525 - 1);
    actStart  = cfgStd ? HW'(START_625)     : HW'(START_525);
    frameLast = cfgStd ? VW'(LINES_625 - 1) : VW'(LINES_525 - 1);
    field0    = cfgStd ? VW'(FIELD0_625)    : VW'(FIELD0_525);
    vblLines  = cfgStd ? VW'(VBLANK_625)    : VW'(VBLANK_525);

    inF2        = vCnt >= field0;
    lineInField = inF2 ? vCnt - field0 : vCnt;
    syncLine    = lineInField < VW'(VSYNC_LINES);

    colRel     = {1'b0, hCnt} - {1'b0, actStart};
    eavOff     = colRel - (HW+1)'(ACT_SPAN);
    afterStart = hCnt >= actStart;
    syncEnd    = {1'b0, lineLast} + (HW+1)'(1) - (HW+1)'(HSYNC_W);

    strb.live     = primed;
    strb.wide     = cfgWide;
    strb.active   = afterStart && (colRel < (HW+1)'(ACT_SPAN));
    strb.even     = ~colRel[0];
    strb.vblank   = lineInField < vblLines;
    strb.fieldId  = inF2;
    strb.savSlot  = !afterStart && (({1'b0, hCnt} + (HW+1)'(4)) >= {1'b0, actStart});
    strb.eavSlot  = afterStart && (colRel >= (HW+1)'(ACT_SPAN))
                    && (colRel < (HW+1)'(ACT_SPAN + 4));
    strb.codeIdx  = strb.eavSlot ? eavOff[1:0] : colRel[1:0];
    strb.csyncLow = syncLine ? ({1'b0, hCnt} < syncEnd)
                             : ({1'b0, hCnt} < (HW+1)'(HSYNC_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt    <= '0;
      vCnt    <= '0;
      cfgWide <= 1'b1;
      cfgStd  <= 1'b1;
      primed  <= 1'b0;
    end else if (!primed) begin
      primed  <= 1'b1;
      cfgWide <= wideMode;
      cfgStd  <= std625;
    end else if (hCnt == lineLast) begin
      hCnt <= '0;
      if (vCnt == frameLast) begin
        vCnt    <= '0;
        cfgWide <= wideMode;
        cfgStd  <= std625;
      end else begin
        vCnt <= vCnt + VW'(1);
      end
    end else begin
      hCnt <= hCnt + HW'(1);
    end
  end

endmodule

// File: rtl/vot_dpath.sv
module vot_dpath
  import vot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  vot_strobe_t strb,
  input  logic        pixValid,
  input  logic [7:0]  pixY,
  input  logic [7:0]  pixC,
  output logic [7:0]  lumaOut,
  output logic [7:0]  chromaOut,
  output logic        qualOut,
  output logic        hrefOut,
  output logic        vsyncOut,
  output logic        csyncOut
);
  logic [7:0] holdY, holdC, inY, inC, codeByte, blankMux;
  logic       showPix;

  always_comb begin
    showPix  = strb.active && !strb.vblank;
    inY      = pixValid ? pixY : LUMA_BLANK;
    inC      = pixValid ? pixC : CHROMA_BLANK;
    blankMux = strb.even ? CHROMA_BLANK : LUMA_BLANK;
    unique case (strb.codeIdx)
      2'd0:    codeByte = 8'hFF;
      2'd3:    codeByte = codeWord(strb.fieldId, strb.vblank, strb.eavSlot);
      default: codeByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lumaOut   <= LUMA_BLANK;
      chromaOut <= CHROMA_BLANK;
      holdY     <= LUMA_BLANK;
      holdC     <= CHROMA_BLANK;
      qualOut   <= 1'b0;
      hrefOut   <= 1'b0;
      vsyncOut  <= 1'b0;
      csyncOut  <= 1'b1;
    end else if (strb.live) begin
      hrefOut  <= showPix;
      vsyncOut <= strb.vblank;
      csyncOut <= !strb.csyncLow;
      qualOut  <= strb.wide && strb.even;
      if (showPix && strb.even) begin
        holdY <= inY;
        holdC <= inC;
      end
      if (strb.wide) begin
        if (showPix) begin
          lumaOut   <= strb.even ? inY : holdY;
          chromaOut <= strb.even ? inC : holdC;
        end else begin
          lumaOut   <= LUMA_BLANK;
          chromaOut <= CHROMA_BLANK;
        end
      end else begin
        chromaOut <= CHROMA_BLANK;
        if (showPix)                          lumaOut <= strb.even ? inC : holdY;
        else if (strb.savSlot || strb.eavSlot) lumaOut <= codeByte;
        else                                  lumaOut <= blankMux;
      end
    end
  end

endmodule

// File: rtl/vid_out_timing.sv
module vid_out_timing
  import vot_pkg::*;
#(
  parameter int ACT_PIX     = 720,
  parameter int LINE_625    = 1728,
  parameter int LINE_525    = 1716,
  parameter int START_625   = 264,
  parameter int START_525   = 244,
  parameter int LINES_625   = 625,
  parameter int LINES_525   = 525,
  parameter int FIELD0_625  = 312,
  parameter int FIELD0_525  = 262,
  parameter int VBLANK_625  = 24,
  parameter int VBLANK_525  = 21,
  parameter int HSYNC_W     = 128,
  parameter int VSYNC_LINES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wideMode,
  input  logic       std625,
  input  logic       pixValid,
  input  logic [7:0] pixY,
  input  logic [7:0] pixC,
  output logic       pixReady,
  output logic [7:0] lumaOut,
  output logic [7:0] chromaOut,
  output logic       qualOut,
  output logic       hrefOut,
  output logic       vsyncOut,
  output logic       csyncOut
);
  vot_strobe_t strb;

  vot_ctrl #(
    .ACT_PIX(ACT_PIX), .LINE_625(LINE_625), .LINE_525(LINE_525),
    .START_625(START_625), .START_525(START_525),
    .LINES_625(LINES_625), .LINES_525(LINES_525),
    .FIELD0_625(FIELD0_625), .FIELD0_525(FIELD0_525),
    .VBLANK_625(VBLANK_625), .VBLANK_525(VBLANK_525),
    .HSYNC_W(HSYNC_W), .VSYNC_LINES(VSYNC_LINES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .std625(std625), .strb(strb)
  );

  vot_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .pixValid(pixValid), .pixY(pixY), .pixC(pixC),
    .lumaOut(lumaOut), .chromaOut(chromaOut), .qualOut(qualOut),
    .hrefOut(hrefOut), .vsyncOut(vsyncOut), .csyncOut(csyncOut)
  );

  assign pixReady = strb.live && strb.active && !strb.vblank && strb.even;

endmodule

// File: rtl/vid_out_timing_chk.sv
module vid_out_timing_chk (
  input logic clk,
  input logic rstN,
  input logic pixReady,
  input logic hrefOut,
  input logic vsyncOut,
  input logic csyncOut,
  input logic qualOut
);
  // R9: a beat is taken only on the first clock of a pixel
  a_r9_ready_alternates: assert property (@(posedge clk) disable iff (!rstN)
    pixReady |=> !pixReady);

  // R2: the first active output clock was preceded by a fetch
  a_r2_href_after_fetch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hrefOut) |-> $past(pixReady));

  // R3: no active picture during vertical blanking
  a_r3_href_not_in_vblank: assert property (@(posedge clk) disable iff (!rstN)
    hrefOut |-> !vsyncOut);

  // R4: sync is released throughout the active window
  a_r4_csync_high_in_active: assert property (@(posedge clk) disable iff (!rstN)
    hrefOut |-> csyncOut);

  // R5: qualifier never stays high for two clocks
  a_r5_qual_toggles: assert property (@(posedge clk) disable iff (!rstN)
    qualOut |=> !qualOut);
endmodule

bind vid_out_timing vid_out_timing_chk chk_i (
  .clk(clk), .rstN(rstN), .pixReady(pixReady), .hrefOut(hrefOut),
  .vsyncOut(vsyncOut), .csyncOut(csyncOut), .qualOut(qualOut)
);

// File: tb/vid_out_timing_tb_top.sv
`timescale 1ns/1ps
module vid_out_timing_tb_top;
  localparam int BN = 8;
  localparam int BL625 = 40, BL525 = 36;
  localparam int BS625 = 14, BS525 = 12;
  localparam int BF625 = 11, BF525 = 9;
  localparam int BH625 = 5,  BH525 = 4;
  localparam int BV625 = 2,  BV525 = 2;
  localparam int HSW = 4, VSL = 1;

  logic clk = 1'b0, rstN = 1'b1;
  logic wideMode, std625, pixValid;
  logic [7:0] pixY, pixC;
  logic pixReady, qualOut, hrefOut, vsyncOut, csyncOut;
  logic [7:0] lumaOut, chromaOut;

  always #2 clk = ~clk;

  vid_out_timing #(
    .ACT_PIX(BN), .LINE_625(BL625), .LINE_525(BL525),
    .START_625(BS625), .START_525(BS525),
    .LINES_625(BF625), .LINES_525(BF525),
    .FIELD0_625(BH625), .FIELD0_525(BH525),
    .VBLANK_625(BV625), .VBLANK_525(BV525),
    .HSYNC_W(HSW), .VSYNC_LINES(VSL)
  ) dut_i (
    .clk(clk), .rstN(rstN), .wideMode(wideMode), .std625(std625),
    .pixValid(pixValid), .pixY(pixY), .pixC(pixC), .pixReady(pixReady),
    .lumaOut(lumaOut), .chromaOut(chromaOut), .qualOut(qualOut),
    .hrefOut(hrefOut), .vsyncOut(vsyncOut), .csyncOut(csyncOut)
  );

  typedef struct packed { logic ok; logic [7:0] y; logic [7:0] c; } beat_t;
  beat_t sbq[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lenOf(bit s);   return s ? BL625 : BL525; endfunction
  function automatic int startOf(bit s); return s ? BS625 : BS525; endfunction
  function automatic int linesOf(bit s); return s ? BF625 : BF525; endfunction
  function automatic int fld0Of(bit s);  return s ? BH625 : BH525; endfunction
  function automatic int vblOf(bit s);   return s ? BV625 : BV525; endfunction
  function automatic logic [7:0] xy(bit f, bit v, bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction
  function automatic bit readyAt(int h, int v, bit s);
    int a = h - startOf(s);
    int lif = (v >= fld0Of(s)) ? v - fld0Of(s) : v;
    return (a >= 0) && (a < 2*BN) && (a % 2 == 0) && (lif >= vblOf(s));
  endfunction

  // scoreboard model state
  int cntH, cntV, showH, showV, cyc, frames;
  bit cfgW, cfgS, showW, showS, showValid;
  beat_t hold, cur;
  logic [1:0] sched [6] = '{2'b11, 2'b01, 2'b10, 2'b00, 2'b11, 2'b11};

  task automatic monitor();
    int st = startOf(showS);
    int a = showH - st;
    bit fid = showV >= fld0Of(showS);
    int lif = fid ? showV - fld0Of(showS) : showV;
    bit vbk = lif < vblOf(showS);
    bit inAct = (a >= 0) && (a < 2*BN);
    bit eCs = (lif < VSL) ? !(showH < lenOf(showS) - HSW) : !(showH < HSW);
    logic [7:0] eL, eC;
    chk("R2", "href", hrefOut, inAct && !vbk);
    chk("R3", "vsync", vsyncOut, vbk);
    chk(showH == 0 ? "R1" : "R4", "csync", csyncOut, eCs);
    chk(showW != wideMode ? "R10" : "R5", "qual", qualOut, showW && ((a & 1) == 0));
    if (inAct && !vbk) begin
      if (a % 2 == 0) begin
        if (sbq.size() == 0) begin
          errors++; checks++;
          $display("FAIL R9 scoreboard empty actual=0 expected=1");
          cur = '0;
        end else cur = sbq.pop_front();
        hold = cur;
      end else cur = hold;
      eL = cur.ok ? cur.y : 8'h10;
      eC = cur.ok ? cur.c : 8'h80;
      if (showW) begin
        chk(cur.ok ? "R5" : "R9", "luma", lumaOut, eL);
        chk(cur.ok ? "R5" : "R9", "chroma", chromaOut, eC);
      end else begin
        chk("R6", "mux", lumaOut, (a % 2 == 0) ? eC : eL);
        chk("R6", "chroma idle", chromaOut, 8'h80);
      end
    end else if (showW) begin
      chk("R8", "luma blank", lumaOut, 8'h10);
      chk("R8", "chroma blank", chromaOut, 8'h80);
    end else begin
      chk("R6", "chroma idle", chromaOut, 8'h80);
      if (a >= -4 && a < 0) begin
        int i = a + 4;
        chk("R7", "sav", lumaOut, i == 0 ? 8'hFF : (i == 3 ? xy(fid, vbk, 0) : 8'h00));
      end else if (a >= 2*BN && a < 2*BN + 4) begin
        int i = a - 2*BN;
        chk("R7", "eav", lumaOut, i == 0 ? 8'hFF : (i == 3 ? xy(fid, vbk, 1) : 8'h00));
      end else begin
        chk("R8", "mux blank", lumaOut, (a % 2 == 0) ? 8'h80 : 8'h10);
      end
    end
  endtask

  initial begin
    wideMode = 1'b1; std625 = 1'b1; pixValid = 1'b0; pixY = '0; pixC = '0;
    #1 rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "reset luma", lumaOut, 8'h10);
    chk("R11", "reset chroma", chromaOut, 8'h80);
    chk("R11", "reset href", hrefOut, 1'b0);
    chk("R11", "reset vsync", vsyncOut, 1'b0);
    chk("R11", "reset csync", csyncOut, 1'b1);
    chk("R11", "reset qual", qualOut, 1'b0);
    chk("R11", "reset ready", pixReady, 1'b0);
    rstN = 1'b1;
    cfgW = wideMode; cfgS = std625; cntH = 0; cntV = 0; showValid = 0;
    @(posedge clk); @(negedge clk);
    chk("R11", "prime csync", csyncOut, 1'b1);
    chk("R11", "prime href", hrefOut, 1'b0);
    frames = 0; cyc = 0;
    while (frames < 5) begin
      if (showValid) monitor();
      cyc++;
      pixValid = (cyc % 7) != 3;
      pixY = 8'(cyc * 3 + 1);
      pixC = 8'(cyc * 5 + 7);
      if (cntV == 1 && cntH == 0) {wideMode, std625} = sched[frames + 1];
      chk("R9", "ready", pixReady, readyAt(cntH, cntV, cfgS));
      if (readyAt(cntH, cntV, cfgS)) sbq.push_back('{pixValid, pixY, pixC});
      showH = cntH; showV = cntV; showW = cfgW; showS = cfgS; showValid = 1;
      if (cntH == lenOf(cfgS) - 1) begin
        cntH = 0;
        if (cntV == linesOf(cfgS) - 1) begin
          cntV = 0; cfgW = wideMode; cfgS = std625; frames++;
        end else cntV++;
      end else cntH++;
      @(posedge clk); @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule